// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block issues the fixed command script that an SDRAM device must receive before it accepts normal reads and writes. A single start strobe begins the script. The sequencer drives clock-enable high on every clock-enable output and then walks a fixed list of commands. The list opens with a precharge of all banks, framed by idle (NOP) cycles. A long run of auto-refresh commands follows. The script closes by writing the mode register.

The burst length, burst type and CAS latency fields are captured when the strobe is accepted. They are packed into the mode word that appears on the address lines during the mode-register write. When the script completes, a done flag rises and stays high until reset. The device bus then sits in NOP. The memory controller holds off normal traffic until that flag is high.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted and after it is released, clock-enable is 0 on every output, the command bundle is DESELECT (1111111), address and bank are 0, and `init_done` is 0, until a start is accepted.
- R2: A start sampled high in the idle state drives every clock-enable output to 1 in the following cycle, with DESELECT still on the command bundle. Clock-enable stays 1 until reset, and no command other than DESELECT is issued while it is 0.
- R3: After the DESELECT cycle the commands run NOP, PRECHARGE ALL, NOP, NOP, one command per clock.
- R4: PRECHARGE ALL is command 1010010. It carries address bit 10 set, all other address bits 0, and bank 0.
- R5: After the precharge group, the block issues REFRESH (1010001) followed by NOP, repeated 32 times, which gives 16 passes of REFRESH, NOP, REFRESH, NOP.
- R6: The last command is MODE REGISTER SET (1010000) with bank 0. The address lines carry the burst length in bits [2:0], the burst type in bit 3, the CAS latency in bits [6:4], 00 in bits [8:7], 1 in bit 9, and 0 in every higher bit.
- R7: The mode word uses the configuration fields present in the cycle the start is accepted. Later changes to these fields have no effect. With burst length 1 (000), sequential type (0) and CAS latency 2 (010), the word is 0x220.
- R8: `init_done` rises in the cycle after MODE REGISTER SET. It stays high until reset, and the command bundle is NOP from then on.
- R9: A start strobe sampled while the script runs, or after it has finished, has no effect on the command stream or on `init_done`.
- R10: Each command occupies exactly one clock cycle. The MODE REGISTER SET appears 70 cycles after the start is accepted, counting the DESELECT cycle as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, acted on only in the idle state |
| cfg_burst_len | input | 3 | Burst length code (000=1, 001=2, 010=4, 011=8) |
| cfg_burst_type | input | 1 | 0 sequential, 1 interleaved |
| cfg_cas_lat | input | 3 | CAS latency code |
| cke_o | output | CKE_W (2) | Clock-enable outputs |
| cmd_o | output | 7 | Command bundle: four chip selects, RAS, CAS, WE |
| addr_o | output | ROW_W (13) | Address lines |
| bank_o | output | BANK_W (2) | Bank select |
| init_done | output | 1 | High once the script has completed |

## Verification
Two things can land in the same cycle: a start strobe and an active step of the script. The bench raises start in the middle of the refresh run, in the exact cycle that shows MODE REGISTER SET, and in the first cycle with `init_done` high. It also changes the configuration fields once the script has started. For each case, the scoreboard compares every cycle's command, address, bank, clock-enable and done flag against the script that an undisturbed start would produce. Any restart, any shift of the refresh run or any change to the mode word appears as a miscompare.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;
  typedef logic [6:0] cmd_t;
  localparam cmd_t CMD_DESEL = 7'b1111111;
  localparam cmd_t CMD_NOP   = 7'b1010111;
  localparam cmd_t CMD_PRE   = 7'b1010010;
  localparam cmd_t CMD_REF   = 7'b1010001;
  localparam cmd_t CMD_MRS   = 7'b1010000;
  // Steps before the refresh loop: deselect, nop, precharge, nop, nop
  localparam int unsigned REF_FIRST = 5;
  // Commands per refresh pass: ref, nop, ref, nop
  localparam int unsigned PASS_LEN  = 4;
endpackage

// File: rtl/init_step_ctr.sv
module init_step_ctr #(
  parameter int unsigned LAST = 69,
  parameter int unsigned SW   = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          active,
  output logic          done,
  output logic [SW-1:0] step
);
  logic          active_n, done_n;
  logic [SW-1:0] step_n;

  always_comb begin
    active_n = active;
    done_n   = done;
    step_n   = step;
    if (!active && !done && start) begin
      active_n = 1'b1;
      step_n   = '0;
    end else if (active) begin
      if (step == SW'(LAST)) begin
        active_n = 1'b0;
        done_n   = 1'b1;
      end else begin
        step_n = step + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      done   <= 1'b0;
      step   <= '0;
    end else begin
      active <= active_n;
      done   <= done_n;
      step   <= step_n;
    end
  end

  // R10
  step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && step != SW'(LAST)) |=> (active && step == $past(step) + 1'b1));
  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active || done) |=> (step != '0 || !active));
endmodule

// File: rtl/init_mode_word.sv
module init_mode_word #(
  parameter int unsigned ROW_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [2:0]       burst_len,
  input  logic             burst_type,
  input  logic [2:0]       cas_lat,
  output logic [ROW_W-1:0] mode
);
  logic [6:0] fields_q, fields_n;

  always_comb begin
    fields_n = fields_q;
    if (capture) fields_n = {cas_lat, burst_type, burst_len};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fields_q <= '0;
    else        fields_q <= fields_n;
  end

  always_comb begin
    mode      = '0;
    mode[6:0] = fields_q;
    mode[9]   = 1'b1;
  end

  // R7
  fields_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(capture) |-> $stable(mode));
endmodule

// File: rtl/init_cmd_decode.sv
module init_cmd_decode
  import sdram_init_pkg::*;
#(
  parameter int unsigned ROW_W  = 13,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned AP_BIT = 10,
  parameter int unsigned LAST   = 69,
  parameter int unsigned SW     = 7
) (
  input  logic              active,
  input  logic              done,
  input  logic [SW-1:0]     step,
  input  logic [ROW_W-1:0]  mode,
  output cmd_t              cmd,
  output logic [ROW_W-1:0]  addr,
  output logic [BANK_W-1:0] bank
);
  logic [SW-1:0] loop_idx;

  assign loop_idx = step - SW'(REF_FIRST);

  always_comb begin
    cmd  = CMD_DESEL;
    addr = '0;
    bank = '0;
    if (done) begin
      cmd = CMD_NOP;
    end else if (active) begin
      if (step == '0) begin
        cmd = CMD_DESEL;
      end else if (step == SW'(2)) begin
        cmd          = CMD_PRE;
        addr[AP_BIT] = 1'b1;
      end else if (step < SW'(REF_FIRST)) begin
        cmd = CMD_NOP;
      end else if (step == SW'(LAST)) begin
        cmd  = CMD_MRS;
        addr = mode;
      end else begin
        cmd = loop_idx[0] ? CMD_NOP : CMD_REF;
      end
    end
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned CKE_W  = 2,
  parameter int unsigned ROW_W  = 13,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned AP_BIT = 10,
  parameter int unsigned PASSES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_burst_type,
  input  logic [2:0]        cfg_cas_lat,
  output logic [CKE_W-1:0]  cke_o,
  output logic [6:0]        cmd_o,
  output logic [ROW_W-1:0]  addr_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              init_done
);
  localparam int unsigned LAST = REF_FIRST + PASS_LEN * PASSES;
  localparam int unsigned SW   = $clog2(LAST + 1);

  logic             active, done, accept;
  logic [SW-1:0]    step;
  logic [ROW_W-1:0] mode;
  cmd_t             cmd;
  logic             cke_q, cke_n;

  assign accept = start && !active && !done;

  init_step_ctr #(.LAST(LAST), .SW(SW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .start(start),
    .active(active), .done(done), .step(step)
  );

  init_mode_word #(.ROW_W(ROW_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .capture(accept),
    .burst_len(cfg_burst_len), .burst_type(cfg_burst_type),
    .cas_lat(cfg_cas_lat), .mode(mode)
  );

  init_cmd_decode #(.ROW_W(ROW_W), .BANK_W(BANK_W), .AP_BIT(AP_BIT),
                    .LAST(LAST), .SW(SW)) u_dec (
    .active(active), .done(done), .step(step), .mode(mode),
    .cmd(cmd), .addr(addr_o), .bank(bank_o)
  );

  always_comb begin
    cke_n = cke_q;
    if (accept) cke_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cke_q <= 1'b0;
    else        cke_q <= cke_n;
  end

  for (genvar g = 0; g < CKE_W; g++) begin : g_cke
    assign cke_o[g] = cke_q;
  end

  assign cmd_o     = cmd;
  assign init_done = done;

  // R2
  cmd_needs_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o != CMD_DESEL) |-> (cke_o == '1));
  // R2
  cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_o == '1) |=> (cke_o == '1));
  // R4
  pre_all_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_PRE) |-> (addr_o == (ROW_W'(1) << AP_BIT) && bank_o == '0));
  // R5
  ref_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_REF) |=> (cmd_o == CMD_NOP));
  // R6
  mrs_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_MRS) |-> (bank_o == '0 && addr_o[9] && addr_o[8:7] == 2'b00));
  // R8
  done_after_mrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_MRS) |=> (init_done && cmd_o == CMD_NOP));
  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> (init_done && cmd_o == CMD_NOP));
endmodule

// File: tb/sdram_init_seq_test.sv
module sdram_init_seq_test;
  typedef struct {
    logic [1:0]  cke;
    logic [6:0]  cmd;
    logic [12:0] addr;
    logic [1:0]  bank;
    logic        done;
    string       tag;
  } item_t;

  localparam logic [6:0] DESEL = 7'b1111111, NOP = 7'b1010111,
                         PRE = 7'b1010010, REF = 7'b1010001, MRS = 7'b1010000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  bl = 3'b000;
  logic        bt = 1'b0;
  logic [2:0]  cl = 3'b010;
  logic [1:0]  cke;
  logic [6:0]  cmd;
  logic [12:0] addr;
  logic [1:0]  bank;
  logic        done;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  item_t q[$];

  always #4 clk = ~clk;

  sdram_init_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_burst_len(bl), .cfg_burst_type(bt), .cfg_cas_lat(cl),
    .cke_o(cke), .cmd_o(cmd), .addr_o(addr), .bank_o(bank), .init_done(done)
  );

  task automatic compare(item_t e);
    vectors++;
    if (cke !== e.cke || cmd !== e.cmd || addr !== e.addr ||
        bank !== e.bank || done !== e.done) begin
      errors++;
      $display("FAIL %s: got cke=%b cmd=%b addr=%h bank=%0d done=%b, expected cke=%b cmd=%b addr=%h bank=%0d done=%b",
               e.tag, cke, cmd, addr, bank, done, e.cke, e.cmd, e.addr, e.bank, e.done);
    end
  endtask

  function automatic item_t mk(logic [1:0] k, logic [6:0] c, logic [12:0] a,
                               logic d, string t);
    item_t it;
    it.cke = k; it.cmd = c; it.addr = a; it.bank = 2'd0; it.done = d; it.tag = t;
    return it;
  endfunction

  // Monitor: sample 3 ns after each rising edge, away from both edges
  always @(posedge clk) begin
    #3;
    if (q.size() > 0) compare(q.pop_front());
  end

  // Driver: accept start, push the expected script, poke inputs during it
  task automatic run(logic [2:0] b_len, logic b_typ, logic [2:0] c_lat,
                     int poke1, int poke2, int cfg_chg, string extra);
    logic [12:0] mw;
    @(negedge clk);
    bl = b_len; bt = b_typ; cl = c_lat; start = 1'b1;
    mw = 13'h200 | {6'd0, c_lat, b_typ, b_len};
    q.push_back(mk(2'b11, DESEL, 13'h0, 1'b0, {"R2", extra}));
    q.push_back(mk(2'b11, NOP,   13'h0, 1'b0, {"R3", extra}));
    q.push_back(mk(2'b11, PRE,   13'h400, 1'b0, {"R3 R4", extra}));
    q.push_back(mk(2'b11, NOP,   13'h0, 1'b0, {"R3", extra}));
    q.push_back(mk(2'b11, NOP,   13'h0, 1'b0, {"R3", extra}));
    for (int p = 0; p < 32; p++) begin
      q.push_back(mk(2'b11, REF, 13'h0, 1'b0, {"R5", extra}));
      q.push_back(mk(2'b11, NOP, 13'h0, 1'b0, {"R5 R10", extra}));
    end
    q.push_back(mk(2'b11, MRS, mw, 1'b0, {"R6 R7 R10", extra}));
    for (int d = 0; d < 4; d++)
      q.push_back(mk(2'b11, NOP, 13'h0, 1'b1, {"R8", extra}));
    for (int i = 1; i <= 76; i++) begin
      @(negedge clk);
      start = (i == poke1 || i == poke2);
      if (i == cfg_chg) begin
        bl = ~b_len; bt = ~b_typ; cl = ~c_lat;
      end
    end
    start = 1'b0;
    while (q.size() > 0) @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    // R1: state while held in reset
    compare(mk(2'b00, DESEL, 13'h0, 1'b0, "R1"));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: idle after release, no start yet
    compare(mk(2'b00, DESEL, 13'h0, 1'b0, "R1"));
  endtask

  initial begin
    do_reset();
    // Default configuration: word 0x220
    run(3'b000, 1'b0, 3'b010, -1, -1, -1, " R7");
    do_reset();
    // BL8, interleaved, CL3 (0x23B); start mid-refresh, config changed after start
    run(3'b011, 1'b1, 3'b011, 20, 37, 2, " R9");
    do_reset();
    // BL4, sequential, CL2 (0x222); start on MRS cycle and on first done cycle
    run(3'b010, 1'b0, 3'b010, 70, 71, -1, " R9");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles, expected at most 20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule